// File: doc/BRIEF.md
# Banked Debug Register Select Unit

This block holds a small 64-bit control register with one 2-bit bank field. The field picks which group of sixteen breakpoint or watchpoint slots an indexed debug-register access reaches. The block joins the effective bank to the 4-bit low index of the accessed slot, which gives a 6-bit index into 64 entries. Depending on the current privilege level and a per-level bank enable, the bank used for that index is forced to zero.

Every read or write of the register goes through an ordered chain of checks. The outcome of that chain is one of four: the access is performed, it is made undefined, it traps to the hypervisor level (2), or it traps to the top level (3). The request is a single-cycle strobe that the block always accepts. There is no back-pressure: `acc_valid` needs no ready, and the verdict, the read data and the exception fields are all valid in the same cycle as the strobe. A performed write takes effect at the next rising clock edge.

Top module: `dbg_bank_select`

## Requirements
- R1: After reset the stored bank is 00. A performed read returns zero, and `eff_idx` equals the low index.
- R2: Read data carries the bank in bits [5:4]. Bits [63:6] and [3:0] always read zero, and writes to them have no effect.
- R3: When both `bp_count` and `wp_count` are 16 or less, the bank reads as zero, writes leave it unchanged, and `eff_idx` uses a bank of zero.
- R4: A write of bank value b (1 to 3) is stored only if the larger of the two counts exceeds 16*b. Otherwise the stored bank keeps its old value. A write of bank 0 is always stored.
- R5: `eff_idx` = {effective bank, `low_idx`}, with the bank in bits [5:4].
- R6: The bank used for `eff_idx` is zero at level 3 when `top_bank_en`=0, at level 2 when `hyp_bank_en`=0, and at level 1 when `kern_bank_en`=0. At level 0 the stored bank is used.
- R7: The access is undefined when `feat_dbg` or `feat_wide` is 0, or when `cur_lvl` is 0.
- R8: At level 3, with both feature flags set, the access is always performed.
- R9: At levels 1 and 2, when `top_present` and `sdd_prio` are both 1, the access is undefined if `top_bank_en`=0 or `top_dbg_trap`=1. This check comes before all trap checks.
- R10: At level 1, when `hyp_on` and `feat_fg` are both 1, the access traps to level 2 in either case: `top_present`=1 with `top_fg_en`=0, or the active-low fine-grained bit is 0. That bit is `fg_rd_n` for reads and `fg_wr_n` for writes.
- R11: At level 1, when `hyp_on` is 1 and either `hyp_trap_a` or `hyp_trap_b` is 1, the access traps to level 2. This check comes after R10.
- R12: At levels 1 and 2, when `top_present` is 1, the access traps to level 3 if `top_bank_en`=0 or `top_dbg_trap`=1. This trap becomes undefined when `sdd_undef` is 1. Level 2 skips R10 and R11.
- R13: A trap reports `exc_class`=0x18 and `exc_target` = 2 or 3. An access that is not performed leaves the register unchanged, and a read that is not performed returns zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Access strobe, always accepted |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 64 | Write data |
| cur_lvl | input | 2 | Current privilege level, 0 to 3 |
| feat_dbg | input | 1 | Debug extension present |
| feat_wide | input | 1 | 64-bit execution state present |
| feat_fg | input | 1 | Fine-grained trap feature present |
| top_present | input | 1 | Level 3 implemented |
| hyp_on | input | 1 | Level 2 enabled |
| top_bank_en | input | 1 | Level 3 bank enable |
| top_dbg_trap | input | 1 | Level 3 debug trap |
| top_fg_en | input | 1 | Level 3 fine-grained trap enable |
| hyp_bank_en | input | 1 | Level 2 effective bank enable |
| hyp_trap_a | input | 1 | Level 2 debug trap bit A |
| hyp_trap_b | input | 1 | Level 2 debug trap bit B |
| fg_rd_n | input | 1 | Active-low fine-grained read trap |
| fg_wr_n | input | 1 | Active-low fine-grained write trap |
| kern_bank_en | input | 1 | Level 1 effective bank enable |
| sdd_prio | input | 1 | Secure-debug-disable undefined priority |
| sdd_undef | input | 1 | Secure-debug-disable turns level 3 traps undefined |
| bp_count | input | 7 | Implemented breakpoints |
| wp_count | input | 7 | Implemented watchpoints |
| low_idx | input | 4 | Low index of the accessed debug register |
| rd_data | output | 64 | Read data |
| exc_valid | output | 1 | Access not performed |
| exc_undef | output | 1 | Access is undefined |
| exc_trap | output | 1 | Access traps |
| exc_target | output | 2 | Trap target level |
| exc_class | output | 6 | Trap syndrome class |
| eff_idx | output | 6 | Effective breakpoint/watchpoint index |

## Verification
A vector table walks the check chain. Each row starts from a fully permissive set of controls and raises one or two conditions. Pairs of rows separate the checks in the chain: one pair shows that undefined priority wins over a hypervisor trap, another that a hypervisor trap wins over a top-level trap, and a third that the read and write fine-grained bits are independent. Further rows show that level 2 skips the hypervisor checks and that clearing `top_present` disables every top-level check. Directed sequences then vary the breakpoint and watchpoint counts around 16, 32 and 48. These show which bank writes are stored, whether the bank reads as zero, and whether `eff_idx` uses the stored bank or a forced zero at each level.

// File: rtl/dbsel_pkg.sv
package dbsel_pkg;
  typedef enum logic [1:0] {
    PL_USER = 2'd0,
    PL_KERN = 2'd1,
    PL_HYP  = 2'd2,
    PL_TOP  = 2'd3
  } plevel_t;

  typedef enum logic [1:0] {
    ACC_DO       = 2'd0,
    ACC_UNDEF    = 2'd1,
    ACC_TRAP_HYP = 2'd2,
    ACC_TRAP_TOP = 2'd3
  } verdict_t;

  typedef struct packed {
    logic feat_dbg;
    logic feat_wide;
    logic feat_fg;
    logic top_present;
    logic hyp_on;
    logic top_bank_en;
    logic top_dbg_trap;
    logic top_fg_en;
    logic hyp_trap_a;
    logic hyp_trap_b;
    logic fg_rd_n;
    logic fg_wr_n;
    logic sdd_prio;
    logic sdd_undef;
  } gate_ctl_t;

  localparam logic [5:0] TRAP_CLASS = 6'h18;
endpackage

// File: rtl/dbsel_gate.sv
module dbsel_gate
  import dbsel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      valid,
  input  logic      write,
  input  plevel_t   lvl,
  input  gate_ctl_t ctl,
  output verdict_t  verdict
);
  logic fg_bit;
  logic feats_ok;

  // Ordered chain: the first condition that fires decides the outcome.
  always_comb begin
    fg_bit   = write ? ctl.fg_wr_n : ctl.fg_rd_n;
    feats_ok = ctl.feat_dbg && ctl.feat_wide;
    verdict  = ACC_DO;
    if (!feats_ok || lvl == PL_USER)
      verdict = ACC_UNDEF;
    else if (lvl == PL_TOP)
      verdict = ACC_DO;
    else if (ctl.top_present && ctl.sdd_prio && !ctl.top_bank_en)
      verdict = ACC_UNDEF;
    else if (ctl.top_present && ctl.sdd_prio && ctl.top_dbg_trap)
      verdict = ACC_UNDEF;
    else if (lvl == PL_KERN && ctl.hyp_on && ctl.feat_fg &&
             ((ctl.top_present && !ctl.top_fg_en) || !fg_bit))
      verdict = ACC_TRAP_HYP;
    else if (lvl == PL_KERN && ctl.hyp_on && (ctl.hyp_trap_a || ctl.hyp_trap_b))
      verdict = ACC_TRAP_HYP;
    else if (ctl.top_present && (!ctl.top_bank_en || ctl.top_dbg_trap))
      verdict = ctl.sdd_undef ? ACC_UNDEF : ACC_TRAP_TOP;
  end

  AST_USER_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && lvl == PL_USER) |-> verdict == ACC_UNDEF); // R7
  AST_TOP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && lvl == PL_TOP && ctl.feat_dbg && ctl.feat_wide) |-> verdict == ACC_DO); // R8
  AST_SDD_NO_TOP_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ctl.sdd_undef) |-> verdict != ACC_TRAP_TOP); // R12
  AST_HYP_SKIPS_HYPTRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && lvl == PL_HYP) |-> verdict != ACC_TRAP_HYP); // R12
endmodule

// File: rtl/dbsel_bank_reg.sv
module dbsel_bank_reg #(
  parameter int BANK_W = 2,
  parameter int LOW_W  = 4,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [CNT_W-1:0]  cnt_max,
  input  logic              raz,
  output logic [BANK_W-1:0] bank_q
);
  localparam int NBANK     = 1 << BANK_W;
  localparam int BANK_SPAN = 1 << LOW_W;

  logic [NBANK-1:0] legal;
  logic             take;

  // A bank value is legal when some count reaches past its first slot.
  for (genvar b = 0; b < NBANK; b++) begin : g_legal
    if (b == 0) begin : g_zero
      assign legal[b] = 1'b1;
    end else begin : g_upper
      assign legal[b] = cnt_max > CNT_W'(b * BANK_SPAN);
    end
  end

  assign take = wr_en && !raz && legal[wr_bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank_q <= '0;
    else if (take) bank_q <= wr_bank;
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bank_q)); // R13
  AST_HOLD_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && raz) |=> $stable(bank_q)); // R3
endmodule

// File: rtl/dbsel_index.sv
module dbsel_index
  import dbsel_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int LOW_W  = 4,
  localparam int IDX_W = BANK_W + LOW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  plevel_t           lvl,
  input  logic [BANK_W-1:0] bank_q,
  input  logic              raz,
  input  logic              top_bank_en,
  input  logic              hyp_bank_en,
  input  logic              kern_bank_en,
  input  logic [LOW_W-1:0]  low_idx,
  output logic [IDX_W-1:0]  eff_idx
);
  logic              force_zero;
  logic [BANK_W-1:0] bank_use;

  always_comb begin
    unique case (lvl)
      PL_TOP:  force_zero = !top_bank_en;
      PL_HYP:  force_zero = !hyp_bank_en;
      PL_KERN: force_zero = !kern_bank_en;
      default: force_zero = 1'b0;
    endcase
    bank_use = (force_zero || raz) ? '0 : bank_q;
    eff_idx  = {bank_use, low_idx};
  end

  AST_TOP_FORCE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == PL_TOP && !top_bank_en) |-> eff_idx[IDX_W-1:LOW_W] == '0); // R6
  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> eff_idx[LOW_W-1:0] == low_idx); // R5
endmodule

// File: rtl/dbg_bank_select.sv
module dbg_bank_select
  import dbsel_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int BANK_LSB = 4,
  parameter int BANK_W   = 2,
  parameter int LOW_W    = 4,
  parameter int CNT_W    = 7,
  localparam int IDX_W   = BANK_W + LOW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [1:0]        cur_lvl,
  input  logic              feat_dbg,
  input  logic              feat_wide,
  input  logic              feat_fg,
  input  logic              top_present,
  input  logic              hyp_on,
  input  logic              top_bank_en,
  input  logic              top_dbg_trap,
  input  logic              top_fg_en,
  input  logic              hyp_bank_en,
  input  logic              hyp_trap_a,
  input  logic              hyp_trap_b,
  input  logic              fg_rd_n,
  input  logic              fg_wr_n,
  input  logic              kern_bank_en,
  input  logic              sdd_prio,
  input  logic              sdd_undef,
  input  logic [CNT_W-1:0]  bp_count,
  input  logic [CNT_W-1:0]  wp_count,
  input  logic [LOW_W-1:0]  low_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              exc_valid,
  output logic              exc_undef,
  output logic              exc_trap,
  output logic [1:0]        exc_target,
  output logic [5:0]        exc_class,
  output logic [IDX_W-1:0]  eff_idx
);
  localparam int BANK_SPAN = 1 << LOW_W;

  plevel_t           lvl;
  gate_ctl_t         ctl;
  verdict_t          verdict;
  logic [CNT_W-1:0]  cnt_max;
  logic              raz;
  logic [BANK_W-1:0] bank_q;
  logic              wr_en;

  assign lvl     = plevel_t'(cur_lvl);
  assign ctl     = '{feat_dbg: feat_dbg, feat_wide: feat_wide, feat_fg: feat_fg,
                     top_present: top_present, hyp_on: hyp_on,
                     top_bank_en: top_bank_en, top_dbg_trap: top_dbg_trap,
                     top_fg_en: top_fg_en, hyp_trap_a: hyp_trap_a,
                     hyp_trap_b: hyp_trap_b, fg_rd_n: fg_rd_n, fg_wr_n: fg_wr_n,
                     sdd_prio: sdd_prio, sdd_undef: sdd_undef};
  assign cnt_max = (bp_count > wp_count) ? bp_count : wp_count;
  assign raz     = cnt_max <= CNT_W'(BANK_SPAN);
  assign wr_en   = acc_valid && acc_write && verdict == ACC_DO;

  dbsel_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (acc_valid),
    .write   (acc_write),
    .lvl     (lvl),
    .ctl     (ctl),
    .verdict (verdict)
  );

  dbsel_bank_reg #(.BANK_W(BANK_W), .LOW_W(LOW_W), .CNT_W(CNT_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_bank (acc_wdata[BANK_LSB +: BANK_W]),
    .cnt_max (cnt_max),
    .raz     (raz),
    .bank_q  (bank_q)
  );

  dbsel_index #(.BANK_W(BANK_W), .LOW_W(LOW_W)) u_idx (
    .clk          (clk),
    .rst_n        (rst_n),
    .lvl          (lvl),
    .bank_q       (bank_q),
    .raz          (raz),
    .top_bank_en  (top_bank_en),
    .hyp_bank_en  (hyp_bank_en),
    .kern_bank_en (kern_bank_en),
    .low_idx      (low_idx),
    .eff_idx      (eff_idx)
  );

  always_comb begin
    rd_data    = '0;
    exc_valid  = acc_valid && verdict != ACC_DO;
    exc_undef  = acc_valid && verdict == ACC_UNDEF;
    exc_trap   = acc_valid && (verdict == ACC_TRAP_HYP || verdict == ACC_TRAP_TOP);
    exc_target = 2'd0;
    exc_class  = 6'd0;
    if (exc_trap) begin
      exc_target = (verdict == ACC_TRAP_HYP) ? 2'd2 : 2'd3;
      exc_class  = TRAP_CLASS;
    end
    if (acc_valid && !acc_write && verdict == ACC_DO && !raz)
      rd_data[BANK_LSB +: BANK_W] = bank_q;
  end

  AST_RAZ_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && raz) |-> rd_data == '0); // R3
  AST_FAILED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> rd_data == '0); // R13
  AST_FAILED_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && exc_valid) |=> $stable(bank_q)); // R13
endmodule

// File: tb/sim_dbg_bank_select.sv
module sim_dbg_bank_select;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [63:0] acc_wdata = '0;
  logic [1:0]  cur_lvl = 2'd3;
  logic feat_dbg, feat_wide, feat_fg, top_present, hyp_on, top_bank_en;
  logic top_dbg_trap, top_fg_en, hyp_bank_en, hyp_trap_a, hyp_trap_b;
  logic fg_rd_n, fg_wr_n, kern_bank_en, sdd_prio, sdd_undef;
  logic [6:0]  bp_count = 7'd64, wp_count = 7'd64;
  logic [3:0]  low_idx = '0;
  logic [63:0] rd_data;
  logic        exc_valid, exc_undef, exc_trap;
  logic [1:0]  exc_target;
  logic [5:0]  exc_class;
  logic [5:0]  eff_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(PERIOD / 2) clk = ~clk;

  dbg_bank_select u0 (.*);

  // Control order: dbg wide fg tpres hyp tbank tdtrap tfg ha hb frd fwr prio sdd
  localparam logic [13:0] BASE = 14'b1111_1101_0011_00;
  // Row: lvl[20:19] wr[18] ctl[17:4] exp_undef[3] exp_trap[2] exp_tgt[1:0]
  localparam int NV = 24;
  localparam logic [20:0] VEC [NV] = '{
    {2'd1, 1'b0, 14'b11111101001100, 4'b0000}, // R8-style baseline at level 1
    {2'd0, 1'b0, 14'b11111101001100, 4'b1000}, // R7 user level
    {2'd1, 1'b0, 14'b01111101001100, 4'b1000}, // R7 no debug feature
    {2'd3, 1'b0, 14'b10111101001100, 4'b1000}, // R7 beats level 3
    {2'd3, 1'b0, 14'b11111011001110, 4'b0000}, // R8 level 3 ignores traps
    {2'd1, 1'b0, 14'b11111001101110, 4'b1000}, // R9 beats hyp trap
    {2'd1, 1'b0, 14'b11111111000110, 4'b1000}, // R9 beats fine-grained
    {2'd1, 1'b0, 14'b11111101000100, 4'b0110}, // R10 read bit
    {2'd1, 1'b1, 14'b11111101000100, 4'b0000}, // R10 write ignores read bit
    {2'd1, 1'b1, 14'b11111101001000, 4'b0110}, // R10 write bit
    {2'd1, 1'b0, 14'b11111100001100, 4'b0110}, // R10 top fg enable off
    {2'd1, 1'b0, 14'b11101100001100, 4'b0000}, // R10 needs top present
    {2'd1, 1'b0, 14'b11011101000100, 4'b0000}, // R10 needs fg feature
    {2'd1, 1'b0, 14'b11110101100100, 4'b0000}, // R11 needs hyp on
    {2'd1, 1'b0, 14'b11111101011100, 4'b0110}, // R11 trap bit B
    {2'd1, 1'b0, 14'b11111001101100, 4'b0110}, // R11 beats top trap
    {2'd1, 1'b0, 14'b11111001001100, 4'b0111}, // R12 bank enable off
    {2'd1, 1'b0, 14'b11111001001101, 4'b1000}, // R12 sdd undef
    {2'd1, 1'b0, 14'b11111111001100, 4'b0111}, // R12 debug trap
    {2'd2, 1'b0, 14'b11111101010100, 4'b0000}, // R12 level 2 skips hyp
    {2'd2, 1'b0, 14'b11111111001100, 4'b0111}, // R12 level 2 top trap
    {2'd2, 1'b0, 14'b11111111001101, 4'b1000}, // R12 level 2 sdd undef
    {2'd2, 1'b0, 14'b11111001001110, 4'b1000}, // R9 level 2 priority
    {2'd1, 1'b0, 14'b11101011001100, 4'b0000}  // R12 no top level
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [13:0] c);
    {feat_dbg, feat_wide, feat_fg, top_present, hyp_on, top_bank_en, top_dbg_trap,
     top_fg_en, hyp_trap_a, hyp_trap_b, fg_rd_n, fg_wr_n, sdd_prio, sdd_undef} = c;
  endtask

  task automatic do_write(input logic [1:0] l, input logic [63:0] d);
    @(negedge clk);
    cur_lvl = l; acc_valid = 1'b1; acc_write = 1'b1; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] l, input logic [63:0] exp);
    @(negedge clk);
    cur_lvl = l; acc_valid = 1'b1; acc_write = 1'b0;
    #(PERIOD / 4);
    chk(req, rd_data, exp);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic idx_check(input string req, input logic [1:0] l, input logic [3:0] lo,
                           input logic [5:0] exp);
    @(negedge clk);
    cur_lvl = l; low_idx = lo;
    #(PERIOD / 4);
    chk(req, {58'd0, eff_idx}, {58'd0, exp});
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    set_ctl(BASE);
    hyp_bank_en = 1'b1; kern_bank_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_check("R1 read after reset", 2'd3, 64'h0);
    idx_check("R1 index after reset", 2'd3, 4'h5, 6'h05);

    // R2 field layout, R5 index formation
    do_write(2'd3, '1);
    rd_check("R2 bank field only", 2'd3, 64'h30);
    idx_check("R5 bank and low", 2'd3, 4'hA, 6'h3A);
    idx_check("R5 low zero", 2'd3, 4'h0, 6'h30);

    // R6 forced bank per level
    top_bank_en = 1'b0;
    idx_check("R6 top level forced", 2'd3, 4'hA, 6'h0A);
    top_bank_en = 1'b1; hyp_bank_en = 1'b0;
    idx_check("R6 hyp level forced", 2'd2, 4'hA, 6'h0A);
    idx_check("R6 top ignores hyp enable", 2'd3, 4'hA, 6'h3A);
    hyp_bank_en = 1'b1; kern_bank_en = 1'b0;
    idx_check("R6 kernel level forced", 2'd1, 4'hA, 6'h0A);
    kern_bank_en = 1'b1;
    idx_check("R6 kernel level enabled", 2'd1, 4'hA, 6'h3A);
    hyp_bank_en = 1'b0; kern_bank_en = 1'b0;
    idx_check("R6 user level raw", 2'd0, 4'hA, 6'h3A);
    hyp_bank_en = 1'b1; kern_bank_en = 1'b1;

    // R13 failed accesses
    top_bank_en = 1'b0;
    @(negedge clk);
    cur_lvl = 2'd1; acc_valid = 1'b1; acc_write = 1'b1; acc_wdata = 64'h10;
    #(PERIOD / 4);
    chk("R13 trap class", {58'd0, exc_class}, 64'h18);
    chk("R13 trap target", {62'd0, exc_target}, 64'h3);
    @(negedge clk);
    acc_write = 1'b0;
    #(PERIOD / 4);
    chk("R13 trapped read data", rd_data, 64'h0);
    @(negedge clk);
    acc_valid = 1'b0; top_bank_en = 1'b1;
    rd_check("R13 trapped write held", 2'd3, 64'h30);
    do_write(2'd0, 64'h0);
    rd_check("R13 undefined write held", 2'd3, 64'h30);

    // R4 bank legality against counts
    do_write(2'd3, 64'h10);
    rd_check("R4 bank 1 with 64", 2'd3, 64'h10);
    bp_count = 7'd20; wp_count = 7'd3;
    do_write(2'd3, 64'h20);
    rd_check("R4 bank 2 with 20 ignored", 2'd3, 64'h10);
    do_write(2'd3, 64'h0);
    rd_check("R4 bank 0 stored", 2'd3, 64'h0);
    do_write(2'd3, 64'h10);
    rd_check("R4 bank 1 with 20", 2'd3, 64'h10);
    bp_count = 7'd0; wp_count = 7'd33;
    do_write(2'd3, 64'h20);
    rd_check("R4 bank 2 with 33", 2'd3, 64'h20);
    do_write(2'd3, 64'h30);
    rd_check("R4 bank 3 with 33 ignored", 2'd3, 64'h20);

    // R3 read-as-zero with small counts
    bp_count = 7'd16; wp_count = 7'd16;
    rd_check("R3 read as zero", 2'd3, 64'h0);
    idx_check("R3 index bank zero", 2'd3, 4'h7, 6'h07);
    do_write(2'd3, 64'h10);
    bp_count = 7'd64; wp_count = 7'd64;
    rd_check("R3 write ignored", 2'd3, 64'h20);

    // R2 reserved bits ignored
    do_write(2'd3, 64'hFFFF_FFFF_FFFF_FFCF);
    rd_check("R2 reserved bits", 2'd3, 64'h0);

    // Check chain table, counts 64, write data zero
    acc_wdata = '0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cur_lvl = VEC[i][20:19];
      acc_write = VEC[i][18];
      set_ctl(VEC[i][17:4]);
      acc_valid = 1'b1;
      #(PERIOD / 4);
      chk($sformatf("R7-chain row %0d undef (R9 R10 R11 R12)", i),
          {63'd0, exc_undef}, {63'd0, VEC[i][3]});
      chk($sformatf("R8 row %0d trap", i), {63'd0, exc_trap}, {63'd0, VEC[i][2]});
      chk($sformatf("R13 row %0d target", i), {62'd0, exc_target}, {62'd0, VEC[i][1:0]});
      chk($sformatf("R13 row %0d class", i), {58'd0, exc_class},
          VEC[i][2] ? 64'h18 : 64'h0);
    end
    @(negedge clk);
    acc_valid = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule